// File: doc/BRIEF.md
# Next Program Counter Selector

This block owns the program counter of a single-cycle processor and works out where the next instruction comes from. Instruction addresses are always word aligned, so the counter keeps only the 30 upper address bits. The stored value is a word address. On every rising clock edge the counter loads a new value from one of four sources:

- the sequential path, which is the next word or a taken relative branch;
- an absolute jump that keeps the upper page bits of the counter;
- a register-held target;
- a fixed entry address for system calls.

A small condition checker compares the two register operands under a 2-bit branch kind. Its verdict decides whether the sign-extended 16-bit offset is added on the sequential path. The counter plus one is also driven out as the return (link) value for calls.

The block has no state machine beyond the counter register. The counter register is its single state element. Two transitions are named here. "Reset" forces the counter to word address 0. "Advance" loads the selected next address on every clock edge.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_word` is 0, the reset word address.
- R2: After reset, on every rising edge `pc_word` takes the value that `next_pc` had just before that edge.
- R3: With `pc_src` = 0 and no branch taken, `next_pc` equals `pc_word + 1`.
- R4: Branch kind 1 (less than zero) is taken exactly when bit 31 of `rs_val` is 1.
- R5: Branch kind 2 (equal) is taken exactly when `rs_val` equals `rt_val`.
- R6: Branch kind 3 (not equal) is taken exactly when `rs_val` differs from `rt_val`.
- R7: Branch kind 0 is never taken. A taken branch with `pc_src` = 0 gives `next_pc = pc_word + 1 + sign_extend(imm16)`, wrapping modulo 2^30.
- R8: With `pc_src` = 1, `next_pc` is bits 29:26 of `pc_word` followed by the 26-bit `jta`. The branch verdict has no effect on this path.
- R9: With `pc_src` = 2, `next_pc` is bits 31:2 of `rs_val`.
- R10: With `pc_src` = 3, `next_pc` is the parameter `SYSCALL_WADDR`, which defaults to word 0x40.
- R11: `incr_pc` always equals `pc_word + 1` modulo 2^30, so the all-ones counter gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_src | input | 2 | Next-address source: 0 sequential/branch, 1 jump, 2 register, 3 system call |
| br_type | input | 2 | Branch kind: 0 none, 1 less than zero, 2 equal, 3 not equal |
| imm16 | input | 16 | Signed word offset for relative branches |
| jta | input | 26 | Absolute jump word target |
| rs_val | input | 32 | First register operand; also the register jump target |
| rt_val | input | 32 | Second register operand |
| pc_word | output | 30 | Current program counter (word address) |
| next_pc | output | 30 | Word address to be loaded on the next edge |
| incr_pc | output | 30 | Counter plus one, used as the link value |
| br_taken | output | 1 | Branch condition verdict |

## Verification
The outputs `next_pc`, `incr_pc` and `br_taken` are combinational, so each is due in the same cycle as the inputs that produce it. The bench compares these three near the falling edge that follows the drive. `pc_word` changes one rising edge later. The monitor therefore pops each expected item, checks the combinational part, then waits for the next rising edge plus a small delay before comparing the counter. Inputs are driven two time units after a rising edge, so no compare falls on a clock edge.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    typedef enum logic [1:0] {
        BRK_NONE = 2'd0,
        BRK_LTZ  = 2'd1,
        BRK_EQ   = 2'd2,
        BRK_NE   = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        SRC_SEQ  = 2'd0,
        SRC_JUMP = 2'd1,
        SRC_REG  = 2'd2,
        SRC_TRAP = 2'd3
    } pc_src_e;

endpackage

// File: rtl/nextpc_brcheck.sv
module nextpc_brcheck
    import nextpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  br_kind_e        kind,
    output logic            taken
);
    logic same;

    assign same = (op_a == op_b);

    always_comb begin
        unique case (kind)
            BRK_NONE: taken = 1'b0;
            BRK_LTZ:  taken = op_a[XLEN-1];
            BRK_EQ:   taken = same;
            BRK_NE:   taken = !same;
            default:  taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/nextpc_seqadd.sv
module nextpc_seqadd #(
    parameter int PCW  = 30,
    parameter int IMMW = 16
) (
    input  logic [PCW-1:0]  cur,
    input  logic [IMMW-1:0] offset,
    input  logic            use_off,
    output logic [PCW-1:0]  seq_next,
    output logic [PCW-1:0]  plus_one
);
    localparam int EXTW = PCW - IMMW;

    logic [PCW-1:0] off_ext;
    logic [PCW-1:0] addend;

    generate
        if (EXTW > 0) begin : g_ext
            assign off_ext = {{EXTW{offset[IMMW-1]}}, offset};
        end else begin : g_trunc
            assign off_ext = offset[PCW-1:0];
        end
    endgenerate

    // The offset is gated to zero, so one carry-in adder serves both the
    // plain step and the taken branch.
    assign addend   = use_off ? off_ext : '0;
    assign seq_next = cur + addend + PCW'(1);
    assign plus_one = cur + PCW'(1);
endmodule

// File: rtl/nextpc_select.sv
module nextpc_select
    import nextpc_pkg::*;
#(
    parameter int             PCW  = 30,
    parameter int             JTAW = 26,
    parameter int             XLEN = 32,
    parameter logic [PCW-1:0] TRAP_WADDR = '0
) (
    input  pc_src_e         src,
    input  logic [PCW-1:0]  cur,
    input  logic [PCW-1:0]  seq_next,
    input  logic [JTAW-1:0] jump_tgt,
    input  logic [XLEN-1:0] reg_tgt,
    output logic [PCW-1:0]  chosen
);
    localparam int PAGEW = PCW - JTAW;

    logic [PCW-1:0] jump_full;

    generate
        if (PAGEW > 0) begin : g_page
            assign jump_full = {cur[PCW-1 -: PAGEW], jump_tgt};
        end else begin : g_flat
            assign jump_full = jump_tgt[PCW-1:0];
        end
    endgenerate

    always_comb begin
        unique case (src)
            SRC_SEQ:  chosen = seq_next;
            SRC_JUMP: chosen = jump_full;
            SRC_REG:  chosen = reg_tgt[XLEN-1:2];
            SRC_TRAP: chosen = TRAP_WADDR;
            default:  chosen = seq_next;
        endcase
    end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter int               XLEN          = 32,
    parameter int               IMMW          = 16,
    parameter int               JTAW          = 26,
    parameter logic [XLEN-3:0]  RESET_WADDR   = '0,
    parameter logic [XLEN-3:0]  SYSCALL_WADDR = 30'h0000_0040
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      pc_src,
    input  logic [1:0]      br_type,
    input  logic [IMMW-1:0] imm16,
    input  logic [JTAW-1:0] jta,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic [XLEN-3:0] pc_word,
    output logic [XLEN-3:0] next_pc,
    output logic [XLEN-3:0] incr_pc,
    output logic            br_taken
);
    localparam int PCW = XLEN - 2;

    logic [PCW-1:0] pc_q;
    logic [PCW-1:0] seq_next;
    logic [PCW-1:0] chosen;

    nextpc_brcheck #(.XLEN(XLEN)) u_brcheck (
        .op_a  (rs_val),
        .op_b  (rt_val),
        .kind  (br_kind_e'(br_type)),
        .taken (br_taken)
    );

    nextpc_seqadd #(.PCW(PCW), .IMMW(IMMW)) u_seqadd (
        .cur      (pc_q),
        .offset   (imm16),
        .use_off  (br_taken),
        .seq_next (seq_next),
        .plus_one (incr_pc)
    );

    nextpc_select #(
        .PCW        (PCW),
        .JTAW       (JTAW),
        .XLEN       (XLEN),
        .TRAP_WADDR (SYSCALL_WADDR)
    ) u_select (
        .src      (pc_src_e'(pc_src)),
        .cur      (pc_q),
        .seq_next (seq_next),
        .jump_tgt (jta),
        .reg_tgt  (rs_val),
        .chosen   (chosen)
    );

    // State register: Reset -> RESET_WADDR, otherwise Advance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= RESET_WADDR;
        else        pc_q <= chosen;
    end

    assign pc_word = pc_q;
    assign next_pc = chosen;
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
    parameter int               XLEN          = 32,
    parameter int               JTAW          = 26,
    parameter logic [XLEN-3:0]  SYSCALL_WADDR = 30'h0000_0040
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      pc_src,
    input logic [1:0]      br_type,
    input logic [JTAW-1:0] jta,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic [XLEN-3:0] pc_word,
    input logic [XLEN-3:0] next_pc,
    input logic [XLEN-3:0] incr_pc,
    input logic            br_taken
);
    // R1
    reset_value_chk: assert property (@(posedge clk) !rst_n |-> pc_word == '0);

    // R2
    pc_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pc_word == $past(next_pc));

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src == 2'd0 && br_type == 2'd0) |-> next_pc == incr_pc);

    // R4
    ltz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_type == 2'd1 |-> br_taken == rs_val[XLEN-1]);

    // R5
    eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_type == 2'd2 |-> br_taken == (rs_val == rt_val));

    // R6
    ne_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_type == 2'd3 |-> br_taken == (rs_val != rt_val));

    // R7
    no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_type == 2'd0 |-> !br_taken);

    // R8
    jump_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_src == 2'd1 |-> next_pc[JTAW-1:0] == jta);

    // R9
    reg_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_src == 2'd2 |-> next_pc == rs_val[XLEN-1:2]);

    // R10
    trap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_src == 2'd3 |-> next_pc == SYSCALL_WADDR);
endmodule

bind nextpc_unit nextpc_unit_chk #(
    .XLEN          (XLEN),
    .JTAW          (JTAW),
    .SYSCALL_WADDR (SYSCALL_WADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_src   (pc_src),
    .br_type  (br_type),
    .jta      (jta),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .pc_word  (pc_word),
    .next_pc  (next_pc),
    .incr_pc  (incr_pc),
    .br_taken (br_taken)
);

// File: tb/tb_nextpc_unit.sv
`timescale 1ns/1ps
module tb_nextpc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pc_src = 2'd0;
    logic [1:0]  br_type = 2'd0;
    logic [15:0] imm16 = '0;
    logic [25:0] jta = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [29:0] pc_word, next_pc, incr_pc;
    logic        br_taken;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [29:0] nxt;
        logic [29:0] inc;
        logic        tk;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [29:0] mpc = '0;

    always #4 clk = ~clk;

    nextpc_unit dut (
        .clk(clk), .rst_n(rst_n), .pc_src(pc_src), .br_type(br_type),
        .imm16(imm16), .jta(jta), .rs_val(rs_val), .rt_val(rt_val),
        .pc_word(pc_word), .next_pc(next_pc), .incr_pc(incr_pc),
        .br_taken(br_taken)
    );

    task automatic check30(string tag, string what, logic [29:0] act, logic [29:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one stimulus and pushes the model's expectation.
    task automatic step(string tag, logic [1:0] src, logic [1:0] bt,
                        logic [15:0] imm, logic [25:0] jt,
                        logic [31:0] a, logic [31:0] b);
        exp_t e;
        logic tk;
        logic [29:0] seq;
        pc_src = src; br_type = bt; imm16 = imm; jta = jt; rs_val = a; rt_val = b;
        case (bt)
            2'd1:    tk = a[31];
            2'd2:    tk = (a == b);
            2'd3:    tk = (a != b);
            default: tk = 1'b0;
        endcase
        seq = tk ? mpc + 30'd1 + {{14{imm[15]}}, imm} : mpc + 30'd1;
        case (src)
            2'd0:    e.nxt = seq;
            2'd1:    e.nxt = {mpc[29:26], jt};
            2'd2:    e.nxt = a[31:2];
            default: e.nxt = 30'h0000_0040;
        endcase
        e.inc = mpc + 30'd1;
        e.tk  = tk;
        e.tag = tag;
        sb.push_back(e);
        mpc = e.nxt;
        @(posedge clk);
        #2;
    endtask

    // Monitor: combinational results near the falling edge, counter after the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check30(e.tag, "next_pc", next_pc, e.nxt);
                check30("R11", "incr_pc", incr_pc, e.inc);
                check30(e.tag, "br_taken", {29'd0, br_taken}, {29'd0, e.tk});
                @(posedge clk);
                #1;
                check30("R2", "pc_word", pc_word, e.nxt);
            end
        end
    end

    initial begin
        #(8 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check30("R1", "pc_word in reset", pc_word, 30'd0);
        rst_n = 1'b1;
        mpc = '0;
        step("R3", 2'd0, 2'd0, 16'h0000, '0, 32'h0, 32'h0);
        step("R3", 2'd0, 2'd0, 16'h0007, '0, 32'h5, 32'h5);
        step("R4", 2'd0, 2'd1, 16'h0005, '0, 32'h8000_0000, 32'h0);
        step("R4", 2'd0, 2'd1, 16'h0005, '0, 32'h0000_0001, 32'h0);
        step("R5", 2'd0, 2'd2, 16'hFFFC, '0, 32'h1234_5678, 32'h1234_5678);
        step("R5", 2'd0, 2'd2, 16'hFFFC, '0, 32'h1234_5678, 32'h1234_5679);
        step("R6", 2'd0, 2'd3, 16'h0010, '0, 32'hA, 32'hB);
        step("R6", 2'd0, 2'd3, 16'h0010, '0, 32'hA, 32'hA);
        step("R8", 2'd1, 2'd2, 16'h0100, 26'h123_4567, 32'h7, 32'h7);
        step("R9", 2'd2, 2'd0, 16'h0000, '0, 32'hABCD_0123, 32'h0);
        step("R8", 2'd1, 2'd0, 16'h0000, 26'h000_0ABC, 32'h0, 32'h0);
        step("R10", 2'd3, 2'd3, 16'h0022, '0, 32'h1, 32'h2);
        step("R9", 2'd2, 2'd0, 16'h0000, '0, 32'hFFFF_FFFF, 32'h0);
        step("R11", 2'd0, 2'd0, 16'h0000, '0, 32'h0, 32'h0);
        step("R7", 2'd0, 2'd0, 16'h7FFF, '0, 32'h3, 32'h3);
        step("R7", 2'd0, 2'd2, 16'h8000, '0, 32'h9, 32'h9);
        step("R7", 2'd0, 2'd1, 16'h0003, '0, 32'hFFFF_FFF0, 32'h0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule